// File: doc/BRIEF.md
# Configurable adder and logic element

This block is one bit-slice of a configurable logic fabric. Depending on a mode select it behaves either as a one-bit full adder, with optional subtraction, or as a programmable two-input Boolean function. The logic function is an XOR-of-AND-terms (Reed-Muller) expansion whose four coefficients come from configuration bits, so every two-input function can be produced. There is no lookup table. The same XOR and AND gates that form the adder's sum and carry are reused to evaluate the expansion.

In adder mode an add/subtract control inverts the second operand before it enters the adder. When the slice is the least significant bit of a subtraction, the carry-in is driven to 1 from outside so that the two's-complement result forms. The element holds no state: its outputs follow its inputs combinationally. Slices are chained externally through carry-in and carry-out.

Top module: `cfg_logic_slice`

## Requirements
- R1: With mode = 0 (adder), result equals op_x XOR op_y' XOR carry_in, where op_y' = op_y XOR sub_en.
- R2: With mode = 0, the two-bit value {carry_out, result} equals the arithmetic sum op_x + op_y' + carry_in.
- R3: With mode = 0, sub_en = 1 and carry_in = 1, result equals op_x XOR op_y and carry_out is 1 exactly when op_x >= op_y (no borrow).
- R4: With mode = 1 (logic), result equals cfg[0] XOR (cfg[1] AND op_x) XOR (cfg[2] AND op_y) XOR (cfg[3] AND op_x AND op_y).
- R5: In logic mode, each of the 16 two-input truth tables can be produced by some value of cfg. For a table T, where T[{op_y,op_x}] is the output, the needed coefficients are cfg[0]=T[0], cfg[1]=T[0]^T[1], cfg[2]=T[0]^T[2] and cfg[3]=T[0]^T[1]^T[2]^T[3].
- R6: In logic mode, carry_out is 0.
- R7: In logic mode, sub_en and carry_in have no effect on result.
- R8: In adder mode, cfg has no effect on result or carry_out.
- R9: The element is combinational: both outputs settle within the same time step as an input change, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 1 | First operand / first logic variable |
| op_y | input | 1 | Second operand / second logic variable |
| carry_in | input | 1 | Carry into the slice (adder mode) |
| sub_en | input | 1 | 1 selects subtraction (inverts op_y) in adder mode |
| mode | input | 1 | 0 = adder, 1 = Reed-Muller logic |
| cfg | input | 4 | Reed-Muller coefficients, bit k is coefficient k |
| result | output | 1 | Sum bit or logic function value |
| carry_out | output | 1 | Carry out of the slice; 0 in logic mode |

## Verification
The bench sweeps all 16 truth tables through the coefficient transform and checks all four input combinations of each. A slice that wired a coefficient to the wrong product term would produce the wrong function for some table. It drives subtraction with carry-in forced high for every operand pair, which catches an operand that is not inverted, or a carry that is combined with the wrong term. It also toggles sub_en, carry_in and cfg in the modes where they must be ignored. A leaking select would show up as a flipped result or a nonzero carry_out in logic mode.

// File: rtl/slice_pkg.sv
// Shared definitions for the configurable adder/logic slice.
// Assumes a single-bit datapath; coefficient count fixed by the two-input form.
package slice_pkg;

    // Operating mode of the slice, encoded on the top-level mode pin.
    typedef enum logic {
        MODE_ADD   = 1'b0,
        MODE_LOGIC = 1'b1
    } slice_mode_e;

    // Number of Reed-Muller coefficients for a two-input function.
    localparam int unsigned RM_VARS  = 2;
    localparam int unsigned RM_COEFS = 1 << RM_VARS;

    // Number of terms entering the shared XOR tree.
    localparam int unsigned N_TERMS = RM_COEFS;

endpackage

// File: rtl/slice_operand_prep.sv
// Operand conditioning for the slice.
// In adder mode the second operand is XORed with the subtract control.
// In logic mode it passes unchanged. The shared AND product of the two
// conditioned operands is also formed here, for use by both modes.
// Assumes: purely combinational, single-bit operands.
module slice_operand_prep
    import slice_pkg::*;
(
    input  logic        op_x,
    input  logic        op_y,
    input  logic        sub_en,
    input  slice_mode_e mode,
    output logic        opnd_a,
    output logic        opnd_b,
    output logic        prod_ab
);

    // Condition operands: subtraction only acts in adder mode.
    always_comb begin
        opnd_a = op_x;
        if (mode == MODE_ADD) begin
            opnd_b = op_y ^ sub_en;
        end else begin
            opnd_b = op_y;
        end
        prod_ab = opnd_a & opnd_b;
    end

endmodule

// File: rtl/slice_term_gen.sv
// Term generator. Produces the terms that feed the shared XOR tree.
// Order: [0] first-variable term, [1] second-variable term,
// [2] constant / carry term, [3] product term.
// Adder mode: x, y', cin, 0. Logic mode: c1&x, c2&y, c0, c3&x&y.
// Assumes cfg bit k holds Reed-Muller coefficient k.
module slice_term_gen
    import slice_pkg::*;
#(
    parameter int unsigned NT = N_TERMS
) (
    input  slice_mode_e          mode,
    input  logic                 opnd_a,
    input  logic                 opnd_b,
    input  logic                 prod_ab,
    input  logic                 carry_in,
    input  logic [RM_COEFS-1:0]  cfg,
    output logic [NT-1:0]        terms
);

    // Select each term according to the mode.
    always_comb begin
        terms = '0;
        if (mode == MODE_ADD) begin
            terms[0] = opnd_a;
            terms[1] = opnd_b;
            terms[2] = carry_in;
            terms[3] = 1'b0;
        end else begin
            terms[0] = cfg[1] & opnd_a;
            terms[1] = cfg[2] & opnd_b;
            terms[2] = cfg[0];
            terms[3] = cfg[3] & prod_ab;
        end
    end

endmodule

// File: rtl/slice_xor_tree.sv
// Shared XOR chain. Accumulates the terms in index order. It exposes the
// partial after the first two terms, which is the adder's half-sum,
// and the full parity, which is the result.
// Assumes NT >= 2.
module slice_xor_tree #(
    parameter int unsigned NT = 4
) (
    input  logic [NT-1:0] terms,
    output logic          half_sum,
    output logic          parity
);

    logic [NT-1:0] acc;

    assign acc[0] = terms[0];

    // Ripple the XOR through the remaining terms.
    for (genvar i = 1; i < NT; i++) begin : g_chain
        assign acc[i] = acc[i-1] ^ terms[i];
    end

    assign half_sum = acc[1];
    assign parity   = acc[NT-1];

endmodule

// File: rtl/slice_carry_unit.sv
// Carry formation from the shared gates. The two partial terms cannot
// both be 1, so XOR replaces OR: cout = (a&b) ^ (cin & (a^b)).
// Forced to 0 in logic mode.
// Assumes half_sum is a^b and prod_ab is a&b in adder mode.
module slice_carry_unit
    import slice_pkg::*;
(
    input  slice_mode_e mode,
    input  logic        prod_ab,
    input  logic        half_sum,
    input  logic        carry_in,
    output logic        carry_out
);

    // Combine the generate and propagate partials; gate by mode.
    always_comb begin
        if (mode == MODE_ADD) begin
            carry_out = prod_ab ^ (carry_in & half_sum);
        end else begin
            carry_out = 1'b0;
        end
    end

endmodule

// File: rtl/cfg_logic_slice.sv
// Configurable adder / Reed-Muller logic bit-slice (top).
// mode=0: full adder with optional operand inversion for subtraction.
// mode=1: two-input Reed-Muller function set by cfg.
// Assumes an external driver sets carry_in=1 on the LSB of a subtraction.
// Holds no state.
module cfg_logic_slice
    import slice_pkg::*;
(
    input  logic                op_x,
    input  logic                op_y,
    input  logic                carry_in,
    input  logic                sub_en,
    input  logic                mode,
    input  logic [RM_COEFS-1:0] cfg,
    output logic                result,
    output logic                carry_out
);

    slice_mode_e     mode_e;
    logic            opnd_a;
    logic            opnd_b;
    logic            prod_ab;
    logic [N_TERMS-1:0] terms;
    logic            half_sum;

    assign mode_e = slice_mode_e'(mode);

    slice_operand_prep u_prep (
        .op_x    (op_x),
        .op_y    (op_y),
        .sub_en  (sub_en),
        .mode    (mode_e),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .prod_ab (prod_ab)
    );

    slice_term_gen #(.NT(N_TERMS)) u_terms (
        .mode     (mode_e),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .prod_ab  (prod_ab),
        .carry_in (carry_in),
        .cfg      (cfg),
        .terms    (terms)
    );

    slice_xor_tree #(.NT(N_TERMS)) u_xor (
        .terms    (terms),
        .half_sum (half_sum),
        .parity   (result)
    );

    slice_carry_unit u_carry (
        .mode      (mode_e),
        .prod_ab   (prod_ab),
        .half_sum  (half_sum),
        .carry_in  (carry_in),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/cfg_logic_slice_chk.sv
// Checker for cfg_logic_slice. Uses immediate assertions, because the
// block has no clock. Each check is skipped while any input is unknown.
module cfg_logic_slice_chk (
    input logic       op_x,
    input logic       op_y,
    input logic       carry_in,
    input logic       sub_en,
    input logic       mode,
    input logic [3:0] cfg,
    input logic       result,
    input logic       carry_out
);

    logic [1:0] arith;
    logic [3:0] tt;

    // Check outputs whenever any port changes.
    always_comb begin
        arith = {1'b0, op_x} + {1'b0, op_y ^ sub_en} + {1'b0, carry_in};
        tt[0] = cfg[0];
        tt[1] = cfg[0] ^ cfg[1];
        tt[2] = cfg[0] ^ cfg[2];
        tt[3] = cfg[0] ^ cfg[1] ^ cfg[2] ^ cfg[3];
        if (!$isunknown({op_x, op_y, carry_in, sub_en, mode, cfg})) begin
            // R2
            add_arith_chk: assert (mode || ({carry_out, result} == arith));
            // R3
            sub_borrow_chk: assert (mode || !sub_en || !carry_in ||
                                    ((result == (op_x ^ op_y)) &&
                                     (carry_out == (op_x | ~op_y))));
            // R4
            logic_table_chk: assert (!mode || (result == tt[{op_y, op_x}]));
            // R6
            logic_carry_zero_chk: assert (!mode || !carry_out);
        end
    end

endmodule

bind cfg_logic_slice cfg_logic_slice_chk u_chk (
    .op_x      (op_x),
    .op_y      (op_y),
    .carry_in  (carry_in),
    .sub_en    (sub_en),
    .mode      (mode),
    .cfg       (cfg),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/cfg_logic_slice_test.sv
module cfg_logic_slice_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_x, op_y, carry_in, sub_en, mode;
    logic [3:0] cfg;
    logic       result, carry_out;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    cfg_logic_slice uut (
        .op_x(op_x), .op_y(op_y), .carry_in(carry_in), .sub_en(sub_en),
        .mode(mode), .cfg(cfg), .result(result), .carry_out(carry_out)
    );

    function automatic logic [1:0] exp_add(logic x, logic y, logic ci, logic s);
        logic yb;
        yb = y ^ s;
        return {1'b0, x} + {1'b0, yb} + {1'b0, ci};
    endfunction

    function automatic logic exp_rm(logic [3:0] c, logic x, logic y);
        return c[0] ^ (c[1] & x) ^ (c[2] & y) ^ (c[3] & x & y);
    endfunction

    function automatic logic [3:0] tt_to_cfg(logic [3:0] t);
        return {t[0] ^ t[1] ^ t[2] ^ t[3], t[0] ^ t[2], t[0] ^ t[1], t[0]};
    endfunction

    task automatic apply(logic x, logic y, logic ci, logic s, logic m, logic [3:0] c);
        @(negedge clk);
        op_x = x; op_y = y; carry_in = ci; sub_en = s; mode = m; cfg = c;
        #1;
    endtask

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (x=%b y=%b ci=%b sub=%b mode=%b cfg=%b)",
                     req, act, exp, op_x, op_y, carry_in, sub_en, mode, cfg);
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_bad++;
                    n_vec++;
                    $display("FAIL watchdog: got timeout expected completion");
                    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [1:0] e;
        logic       r0;
        void'($urandom(32'h5A1CE));
        op_x = 0; op_y = 0; carry_in = 0; sub_en = 0; mode = 0; cfg = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R9: all-zero inputs give zero outputs in the same time step
        apply(0, 0, 0, 0, 0, 4'h0);
        check("R9 idle", {carry_out, result}, 2'b00);
        op_y = 1'b1;
        #0.001;
        check("R9 settle", {carry_out, result}, 2'b01);

        // R1 R2: exhaustive add, both sub settings
        for (int v = 0; v < 16; v++) begin
            apply(v[0], v[1], v[2], v[3], 0, 4'h0);
            e = exp_add(v[0], v[1], v[2], v[3]);
            check("R1 sum", {1'b0, result}, {1'b0, e[0]});
            check("R2 carry", {carry_out, result}, e);
        end

        // R3: LSB subtraction with carry_in forced to 1
        for (int v = 0; v < 4; v++) begin
            apply(v[0], v[1], 1, 1, 0, 4'h0);
            check("R3 sub", {carry_out, result},
                  {(v[0] >= v[1]) ? 1'b1 : 1'b0, v[0] ^ v[1]});
        end

        // R5 R4 R6: every truth table through the coefficient transform
        for (int t = 0; t < 16; t++) begin
            for (int v = 0; v < 4; v++) begin
                apply(v[0], v[1], 0, 0, 1, tt_to_cfg(t[3:0]));
                check("R5 table", {1'b0, result}, {1'b0, t[v]});
                check("R4 rm", {1'b0, result}, {1'b0, exp_rm(cfg, v[0], v[1])});
                check("R6 cout", {1'b0, carry_out}, 2'b00);
            end
        end

        // R7: sub_en and carry_in toggled in logic mode
        for (int v = 0; v < 64; v++) begin
            apply(v[0], v[1], 0, 0, 1, v[5:2]);
            r0 = result;
            apply(v[0], v[1], 1, 1, 1, v[5:2]);
            check("R7 ignore", {carry_out, result}, {1'b0, r0});
        end

        // R8: cfg toggled in adder mode
        for (int v = 0; v < 16; v++) begin
            apply(v[0], v[1], v[2], v[3], 0, 4'hF);
            check("R8 ignore", {carry_out, result}, exp_add(v[0], v[1], v[2], v[3]));
        end

        // Random mix: R2 R4 R6
        for (int k = 0; k < 2000; k++) begin
            logic [8:0] rv;
            rv = 9'($urandom);
            apply(rv[0], rv[1], rv[2], rv[3], rv[4], rv[8:5]);
            if (rv[4])
                check("R4 rand", {carry_out, result}, {1'b0, exp_rm(rv[8:5], rv[0], rv[1])});
            else
                check("R2 rand", {carry_out, result}, exp_add(rv[0], rv[1], rv[2], rv[3]));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule